// File: doc/BRIEF.md
# Temperature-Stepped Fan PWM Controller

This block drives a fan's PWM pin from a stream of raw 16-bit temperature samples. It keeps a level from 0 to 4, which maps to 0%, 25%, 50%, 75% and 100% of a fixed PWM period. Eight threshold registers give every step a rising point and a separate, lower falling point, so a temperature near a boundary does not make the duty toggle. Each accepted sample moves the level by one step at most.

Software can read the active width, read the fixed period and read or write the thresholds through a small strobe-based register port. A write to the width register overrides the duty until the next hardware step. A step upward pulses a temperature-increase event. Every duty change, from hardware or from software, starts a settle timer, and a PWM-changed event pulses when the timer runs out. A newer change restarts the timer.

The temperature input is a valid/ready stream. The block never applies back-pressure while it is out of reset: ready equals the reset-release state. A sample is taken on every clock edge where valid and ready are both high, and the source may hold valid high for consecutive samples.

Top module: `fan_pwm_ctrl`

## Requirements
- R1: `temp_ready` equals `rst_n`. A sample is used only on an edge where `temp_valid` and `temp_ready` are both high. A sample offered with `temp_valid` low has no effect on level, width or events.
- R2: While `rst_n` is low, `pwm_out` is held high. After reset the level is 0, the width reads 0 and no event is pending.
- R3: Register map on `reg_addr`: 0 is the width (read/write), 1 is the period (read-only, reads `PWM_PERIOD`), 2..9 are the thresholds in the order 0%-falling, 25%-rising, 25%-falling, 50%-rising, 50%-falling, 75%-rising, 75%-falling, 100%-rising. Any other address reads 0. `reg_rdata` is valid in the cycle after the edge that sampled `reg_rd`. Threshold k resets to (k+1)*`THR_STEP`.
- R4: At level L<4, an accepted sample strictly greater than the rising threshold of level L+1 raises the level by exactly one. A sample equal to that threshold does not.
- R5: At level L>0, an accepted sample strictly below the falling threshold of level L-1 lowers the level by one. Samples between the two thresholds leave the level unchanged.
- R6: On the edge where the hardware level changes, the width becomes level*`PWM_PERIOD`/4.
- R7: `temp_up_evt` is a one-cycle pulse in the cycle after an edge that raised the level. It never pulses for a falling step or for a software write.
- R8: `pwm_chg_evt` pulses for one cycle exactly `SETTLE_CYCLES` cycles after the edge of a duty change. A further change before the pulse restarts the wait, so a burst of changes yields a single pulse.
- R9: A write to address 0 sets the width to the written value, clamped to `PWM_PERIOD`, and counts as a duty change even if the value is unchanged. A write to address 1 has no effect.
- R10: When a software width write and a hardware step share an edge, the written value wins, the level still moves, `temp_up_evt` still pulses for a rise, and only one `pwm_chg_evt` follows.
- R11: Out of reset, `pwm_out` is high while the period counter is below the active width. The active width is reloaded from the width register only at the period boundary.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| temp_valid | input | 1 | Temperature sample valid |
| temp_ready | output | 1 | Sample accepted when high with valid |
| temp_data | input | DATA_W | Raw temperature sample |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | ADDR_W | Register address |
| reg_wdata | input | DATA_W | Register write data |
| reg_rdata | output | DATA_W | Register read data, one cycle after strobe |
| pwm_out | output | 1 | Fan PWM drive |
| temp_up_evt | output | 1 | Hardware raised the duty level |
| pwm_chg_evt | output | 1 | Duty change settled |

## Verification
The collision that matters is a software width write landing on the same edge as a sample that moves the hardware level. Both sources try to load the width and start the settle timer. The bench drives a rising sample and a width write in one cycle. It then checks that the read-back width is the written value, that the temperature-increase event appears once in the following cycle, and that the scoreboard receives exactly one PWM-changed event one settle interval later. A related overlap, a second write arriving while the timer is still running, is used to show that the earlier pending event is dropped rather than delivered.

// File: rtl/fan_pkg.sv
`timescale 1ns/1ps
package fan_pkg;
  localparam int NUM_LEVELS = 5;
  localparam int NUM_THR    = 8;
  localparam int LVL_W      = 3;
  localparam int ADDR_WIDTH_REG  = 0;
  localparam int ADDR_PERIOD_REG = 1;
  localparam int ADDR_THR_BASE   = 2;
  typedef logic [LVL_W-1:0] level_t;
  localparam level_t LVL_MAX = level_t'(NUM_LEVELS - 1);
endpackage

// File: rtl/fan_thermal.sv
`timescale 1ns/1ps
module fan_thermal
  import fan_pkg::*;
#(
  parameter int DATA_W = 16
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic                           accept,
  input  logic [DATA_W-1:0]              temp_data,
  input  logic [NUM_THR-1:0][DATA_W-1:0] thr,
  output logic                           hw_step,
  output level_t                         level_next,
  output level_t                         level_q,
  output logic                           temp_up_evt
);
  logic [2:0] up_idx;
  logic [2:0] dn_idx;
  level_t     dn_lvl;
  logic       go_up;
  logic       go_dn;

  // rising point of level L+1 sits at odd index 2L+1,
  // falling point of level L-1 at even index 2(L-1)
  assign dn_lvl = level_q - level_t'(1);
  assign up_idx = {level_q[1:0], 1'b1};
  assign dn_idx = {dn_lvl[1:0], 1'b0};

  assign go_up = accept && (level_q < LVL_MAX) && (temp_data > thr[up_idx]);
  assign go_dn = accept && !go_up && (level_q != '0) && (temp_data < thr[dn_idx]);

  assign hw_step = go_up || go_dn;

  always_comb begin
    level_next = level_q;
    if (go_up)      level_next = level_q + level_t'(1);
    else if (go_dn) level_next = dn_lvl;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      level_q     <= '0;
      temp_up_evt <= 1'b0;
    end else begin
      level_q     <= level_next;
      temp_up_evt <= go_up;
    end
  end
endmodule

// File: rtl/fan_regs.sv
`timescale 1ns/1ps
module fan_regs
  import fan_pkg::*;
#(
  parameter int DATA_W     = 16,
  parameter int ADDR_W     = 4,
  parameter int PWM_PERIOD = 400,
  parameter int THR_STEP   = 4096,
  parameter int CNT_W      = 9
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic                           reg_wr,
  input  logic                           reg_rd,
  input  logic [ADDR_W-1:0]              reg_addr,
  input  logic [DATA_W-1:0]              reg_wdata,
  output logic [DATA_W-1:0]              reg_rdata,
  input  logic                           hw_step,
  input  level_t                         level_next,
  output logic                           sw_width_wr,
  output logic [CNT_W-1:0]               width_q,
  output logic [NUM_THR-1:0][DATA_W-1:0] thr
);
  localparam int QUARTER = PWM_PERIOD / 4;

  logic [DATA_W-1:0] rd_mux;
  logic [CNT_W-1:0]  sw_width;
  logic [CNT_W-1:0]  hw_width;

  assign sw_width_wr = reg_wr && (reg_addr == ADDR_W'(ADDR_WIDTH_REG));
  assign sw_width    = (reg_wdata > DATA_W'(PWM_PERIOD)) ? CNT_W'(PWM_PERIOD)
                                                         : reg_wdata[CNT_W-1:0];
  assign hw_width    = CNT_W'(level_next) * CNT_W'(QUARTER);

  always_ff @(posedge clk) begin
    if (!rst_n)           width_q <= '0;
    else if (sw_width_wr) width_q <= sw_width;
    else if (hw_step)     width_q <= hw_width;
  end

  for (genvar k = 0; k < NUM_THR; k++) begin : g_thr
    always_ff @(posedge clk) begin
      if (!rst_n)
        thr[k] <= DATA_W'((k + 1) * THR_STEP);
      else if (reg_wr && (reg_addr == ADDR_W'(ADDR_THR_BASE + k)))
        thr[k] <= reg_wdata;
    end
  end

  always_comb begin
    rd_mux = '0;
    if (reg_addr == ADDR_W'(ADDR_WIDTH_REG))  rd_mux = DATA_W'(width_q);
    if (reg_addr == ADDR_W'(ADDR_PERIOD_REG)) rd_mux = DATA_W'(PWM_PERIOD);
    for (int k = 0; k < NUM_THR; k++)
      if (reg_addr == ADDR_W'(ADDR_THR_BASE + k)) rd_mux = thr[k];
  end

  always_ff @(posedge clk) begin
    if (!rst_n)      reg_rdata <= '0;
    else if (reg_rd) reg_rdata <= rd_mux;
  end
endmodule

// File: rtl/fan_settle.sv
`timescale 1ns/1ps
module fan_settle #(
  parameter int SETTLE_CYCLES = 500_000_000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  output logic done_evt
);
  localparam int ST_W = $clog2(SETTLE_CYCLES + 1);

  logic [ST_W-1:0] remain;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      remain   <= '0;
      done_evt <= 1'b0;
    end else begin
      done_evt <= !start && (remain == ST_W'(1));
      if (start)              remain <= ST_W'(SETTLE_CYCLES);
      else if (remain != '0)  remain <= remain - ST_W'(1);
    end
  end
endmodule

// File: rtl/fan_pwm_gen.sv
`timescale 1ns/1ps
module fan_pwm_gen #(
  parameter int PWM_PERIOD = 400,
  parameter int CNT_W      = 9
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [CNT_W-1:0] width_q,
  output logic [CNT_W-1:0] act_w,
  output logic             pwm_out
);
  logic [CNT_W-1:0] phase;
  logic             wrap;

  assign wrap = (phase == CNT_W'(PWM_PERIOD - 1));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      phase <= '0;
      act_w <= '0;
    end else if (wrap) begin
      phase <= '0;
      act_w <= width_q;
    end else begin
      phase <= phase + CNT_W'(1);
    end
  end

  // fan runs flat out while held in reset
  assign pwm_out = !rst_n || (phase < act_w);
endmodule

// File: rtl/fan_pwm_ctrl.sv
`timescale 1ns/1ps
module fan_pwm_ctrl
  import fan_pkg::*;
#(
  parameter int DATA_W        = 16,
  parameter int ADDR_W        = 4,
  parameter int PWM_PERIOD    = 400,
  parameter int SETTLE_CYCLES = 500_000_000,
  parameter int THR_STEP      = 4096
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              temp_valid,
  output logic              temp_ready,
  input  logic [DATA_W-1:0] temp_data,
  input  logic              reg_wr,
  input  logic              reg_rd,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  output logic              pwm_out,
  output logic              temp_up_evt,
  output logic              pwm_chg_evt
);
  localparam int CNT_W = $clog2(PWM_PERIOD + 1);

  logic                           hw_step;
  level_t                         level_next;
  level_t                         level_q;
  logic                           sw_width_wr;
  logic [CNT_W-1:0]               width_q;
  logic [CNT_W-1:0]               act_w;
  logic [NUM_THR-1:0][DATA_W-1:0] thr;

  assign temp_ready = rst_n;

  fan_thermal #(.DATA_W(DATA_W)) u_thermal (
    .clk         (clk),
    .rst_n       (rst_n),
    .accept      (temp_valid && temp_ready),
    .temp_data   (temp_data),
    .thr         (thr),
    .hw_step     (hw_step),
    .level_next  (level_next),
    .level_q     (level_q),
    .temp_up_evt (temp_up_evt)
  );

  fan_regs #(
    .DATA_W(DATA_W), .ADDR_W(ADDR_W), .PWM_PERIOD(PWM_PERIOD),
    .THR_STEP(THR_STEP), .CNT_W(CNT_W)
  ) u_regs (
    .clk         (clk),
    .rst_n       (rst_n),
    .reg_wr      (reg_wr),
    .reg_rd      (reg_rd),
    .reg_addr    (reg_addr),
    .reg_wdata   (reg_wdata),
    .reg_rdata   (reg_rdata),
    .hw_step     (hw_step),
    .level_next  (level_next),
    .sw_width_wr (sw_width_wr),
    .width_q     (width_q),
    .thr         (thr)
  );

  fan_settle #(.SETTLE_CYCLES(SETTLE_CYCLES)) u_settle (
    .clk      (clk),
    .rst_n    (rst_n),
    .start    (hw_step || sw_width_wr),
    .done_evt (pwm_chg_evt)
  );

  fan_pwm_gen #(.PWM_PERIOD(PWM_PERIOD), .CNT_W(CNT_W)) u_pwm (
    .clk     (clk),
    .rst_n   (rst_n),
    .width_q (width_q),
    .act_w   (act_w),
    .pwm_out (pwm_out)
  );
endmodule

// File: rtl/fan_pwm_ctrl_sva.sv
`timescale 1ns/1ps
module fan_pwm_ctrl_sva #(
  parameter int DATA_W     = 16,
  parameter int ADDR_W     = 4,
  parameter int PWM_PERIOD = 400,
  parameter int CNT_W      = 9
) (
  input logic              clk,
  input logic              rst_n,
  input logic              temp_valid,
  input logic              temp_ready,
  input logic              reg_rd,
  input logic [ADDR_W-1:0] reg_addr,
  input logic [DATA_W-1:0] reg_rdata,
  input logic              pwm_out,
  input logic              temp_up_evt,
  input logic              pwm_chg_evt,
  input logic [CNT_W-1:0]  width_q,
  input logic [CNT_W-1:0]  act_w,
  input logic [2:0]        level_q
);
  assert_reset_drive_R2: assert property (@(posedge clk) !rst_n |-> pwm_out);

  assert_period_read_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $past(reg_rd && reg_addr == ADDR_W'(1)) |-> reg_rdata == DATA_W'(PWM_PERIOD));

  assert_level_needs_sample_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (level_q != $past(level_q)) |-> $past(temp_valid && temp_ready));

  assert_level_range_R5: assert property (@(posedge clk) disable iff (!rst_n)
    level_q <= 3'd4);

  assert_up_needs_sample_R7: assert property (@(posedge clk) disable iff (!rst_n)
    temp_up_evt |-> $past(temp_valid && temp_ready));

  assert_chg_single_R8: assert property (@(posedge clk) disable iff (!rst_n)
    pwm_chg_evt |=> !pwm_chg_evt);

  assert_width_clamp_R9: assert property (@(posedge clk) disable iff (!rst_n)
    width_q <= CNT_W'(PWM_PERIOD));

  assert_full_duty_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (act_w == CNT_W'(PWM_PERIOD)) |-> pwm_out);

  assert_zero_duty_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (act_w == '0) |-> !pwm_out);
endmodule

bind fan_pwm_ctrl fan_pwm_ctrl_sva #(
  .DATA_W(DATA_W), .ADDR_W(ADDR_W), .PWM_PERIOD(PWM_PERIOD), .CNT_W(CNT_W)
) u_sva (
  .clk         (clk),
  .rst_n       (rst_n),
  .temp_valid  (temp_valid),
  .temp_ready  (temp_ready),
  .reg_rd      (reg_rd),
  .reg_addr    (reg_addr),
  .reg_rdata   (reg_rdata),
  .pwm_out     (pwm_out),
  .temp_up_evt (temp_up_evt),
  .pwm_chg_evt (pwm_chg_evt),
  .width_q     (width_q),
  .act_w       (act_w),
  .level_q     (level_q)
);

// File: tb/tb_fan_pwm_ctrl.sv
`timescale 1ns/1ps
module tb_fan_pwm_ctrl;
  localparam int P  = 16;
  localparam int S  = 20;
  localparam int DW = 16;
  localparam int AW = 4;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          temp_valid = 1'b0;
  logic          temp_ready;
  logic [DW-1:0] temp_data = '0;
  logic          reg_wr = 1'b0;
  logic          reg_rd = 1'b0;
  logic [AW-1:0] reg_addr = '0;
  logic [DW-1:0] reg_wdata = '0;
  logic [DW-1:0] reg_rdata;
  logic          pwm_out;
  logic          temp_up_evt;
  logic          pwm_chg_evt;

  int n_chk = 0;
  int n_bad = 0;
  int cyc = 0;
  bit finished = 1'b0;
  int up_q[$];
  int chg_q[$];

  fan_pwm_ctrl #(
    .DATA_W(DW), .ADDR_W(AW), .PWM_PERIOD(P), .SETTLE_CYCLES(S), .THR_STEP(4096)
  ) dut (.*);

  always #5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic finish_sim();
    if (!finished) begin
      finished = 1'b1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  endtask

  // scoreboard monitor: events compared against expected cycles
  always @(negedge clk) if (rst_n) begin
    if (up_q.size() > 0 && up_q[0] < cyc) begin
      chk(1'b0, "R7 missing temp_up_evt", 0, up_q[0]); void'(up_q.pop_front());
    end
    if (chg_q.size() > 0 && chg_q[0] < cyc) begin
      chk(1'b0, "R8 missing pwm_chg_evt", 0, chg_q[0]); void'(chg_q.pop_front());
    end
    if (temp_up_evt) begin
      if (up_q.size() > 0 && up_q[0] == cyc) begin
        chk(1'b1, "R7", cyc, cyc); void'(up_q.pop_front());
      end else chk(1'b0, "R7 unexpected temp_up_evt", cyc, -1);
    end
    if (pwm_chg_evt) begin
      if (chg_q.size() > 0 && chg_q[0] == cyc) begin
        chk(1'b1, "R8", cyc, cyc); void'(chg_q.pop_front());
      end else chk(1'b0, "R8 unexpected pwm_chg_evt", cyc, -1);
    end
  end

  // driver: one-cycle stimulus, pushes expected event cycles
  task automatic drive(input bit tv, input int td, input bit wr, input int addr,
                       input int wd, input bit exp_up, input bit exp_chg);
    int now;
    @(posedge clk); #1;
    now = cyc;
    temp_valid = tv; temp_data = DW'(td);
    reg_wr = wr; reg_addr = AW'(addr); reg_wdata = DW'(wd);
    if (exp_up) up_q.push_back(now + 1);
    if (exp_chg) begin
      if (chg_q.size() > 0 && chg_q[$] > now) chg_q[$] = now + 1 + S;
      else chg_q.push_back(now + 1 + S);
    end
    @(posedge clk); #1;
    temp_valid = 1'b0; reg_wr = 1'b0;
  endtask

  task automatic sample(input int td, input bit exp_up, input bit exp_chg);
    drive(1'b1, td, 1'b0, 0, 0, exp_up, exp_chg);
    repeat (S + 4) @(posedge clk);
  endtask

  task automatic wr_reg(input int addr, input int wd, input bit exp_chg);
    drive(1'b0, 0, 1'b1, addr, wd, 1'b0, exp_chg);
  endtask

  task automatic rd_chk(input int addr, input int exp, input string req);
    @(posedge clk); #1;
    reg_rd = 1'b1; reg_addr = AW'(addr);
    @(posedge clk); #1;
    reg_rd = 1'b0;
    @(negedge clk);
    chk(reg_rdata == DW'(exp), req, int'(reg_rdata), exp);
  endtask

  task automatic duty_chk(input int exp, input string req);
    int hi = 0;
    repeat (2 * P) @(posedge clk);
    repeat (P) begin
      @(negedge clk);
      if (pwm_out) hi++;
    end
    chk(hi == exp, req, hi, exp);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    chk(1'b0, "watchdog", cyc, 0);
    finish_sim();
  end

  initial begin
    repeat (4) @(negedge clk);
    chk(pwm_out == 1'b1, "R2 pwm high in reset", int'(pwm_out), 1);
    chk(temp_ready == 1'b0, "R1 ready low in reset", int'(temp_ready), 0);
    @(posedge clk); #1 rst_n = 1'b1;
    @(negedge clk);
    chk(temp_ready == 1'b1, "R1 ready after reset", int'(temp_ready), 1);
    rd_chk(0, 0, "R2 width after reset");
    duty_chk(0, "R2 R11 zero duty after reset");
    rd_chk(1, P, "R3 period");
    rd_chk(5, 16'h4000, "R3 threshold reset value");
    rd_chk(12, 0, "R3 unmapped address");

    // R1: sample with valid low has no effect
    drive(1'b0, 16'hFFFF, 1'b0, 0, 0, 1'b0, 1'b0);
    repeat (S + 4) @(posedge clk);
    rd_chk(0, 0, "R1 ignored sample");

    // R4 R6: one step per sample
    sample(16'h2500, 1'b1, 1'b1);
    rd_chk(0, 4, "R6 level1 width");
    duty_chk(4, "R11 25% duty");
    sample(16'h7000, 1'b1, 1'b1);
    rd_chk(0, 8, "R4 single step to level2");
    sample(16'h7000, 1'b1, 1'b1);
    rd_chk(0, 12, "R4 step to level3");
    sample(16'h7000, 1'b0, 1'b0);
    rd_chk(0, 12, "R4 below rising point");
    sample(16'h9000, 1'b1, 1'b1);
    rd_chk(0, 16, "R6 level4 width");
    duty_chk(16, "R11 full duty");

    // R5: hysteresis
    sample(16'h7800, 1'b0, 1'b0);
    rd_chk(0, 16, "R5 inside hysteresis band");
    sample(16'h6FFF, 1'b0, 1'b1);
    rd_chk(0, 12, "R5 fall to level3");
    duty_chk(12, "R11 75% duty");
    sample(16'h4FFF, 1'b0, 1'b1);
    rd_chk(0, 8, "R5 fall to level2");
    sample(16'h6000, 1'b0, 1'b0);
    rd_chk(0, 8, "R4 equal to threshold");
    sample(16'h6001, 1'b1, 1'b1);
    rd_chk(0, 12, "R4 just above threshold");

    // R9: software override and clamp
    wr_reg(0, 6, 1'b1);
    repeat (S + 4) @(posedge clk);
    rd_chk(0, 6, "R9 software width");
    duty_chk(6, "R11 software duty");
    wr_reg(0, 100, 1'b1);
    repeat (S + 4) @(posedge clk);
    rd_chk(0, 16, "R9 clamp");
    wr_reg(1, 5, 1'b0);
    repeat (S + 4) @(posedge clk);
    rd_chk(1, P, "R9 period write ignored");

    // R8: restart of the settle wait
    wr_reg(0, 3, 1'b1);
    repeat (5) @(posedge clk);
    wr_reg(0, 7, 1'b1);
    repeat (S + 4) @(posedge clk);
    rd_chk(0, 7, "R8 width after restart");

    // R10: software write and hardware rise on one edge (level 3 -> 4)
    drive(1'b1, 16'h9000, 1'b1, 0, 5, 1'b1, 1'b1);
    repeat (S + 4) @(posedge clk);
    rd_chk(0, 5, "R10 software value wins");
    sample(16'h7800, 1'b0, 1'b0);
    rd_chk(0, 5, "R10 level4 kept");

    // R3: threshold write and read-back
    wr_reg(9, 16'hA000, 1'b0);
    rd_chk(9, 16'hA000, "R3 threshold write");

    repeat (S + 4) @(posedge clk);
    chk(up_q.size() == 0 && chg_q.size() == 0, "R8 queues drained",
        up_q.size() + chg_q.size(), 0);
    finish_sim();
  end
endmodule